// File: doc/BRIEF.md
# Compare-Match Timer Channel

A single 16-bit up-counting timer channel with four compare registers (A, B, C, D) and two output pins tied to the C and D compares. The count source is set by a clock-select field. It can be the system clock divided by 1, 2, 4 or 8 from a free-running prescaler. It can also be the rising edges of an external event input, which pass through a two-flop synchroniser. A control bit lets a match on register A return the counter to zero, which gives a programmable period.

Each output pin drives a software-chosen starting level. It keeps that level until the first compare match on its own register. From then on the pin obeys a per-pin match action: hold, force low, force high or invert. Every compare register has a sticky match flag, and software clears a flag by writing 1 to it. Software reaches the block through a single-cycle write port. The counter value is read back on a port.

Top module: `cmp_timer_top`

## Requirements
- R1: While `rst` is high and one clock after it, `count` is 0, `match_flags` is 0 and both pins are 0. All four compare registers reset to 16'hFFFF. The control and action fields reset to 0.
- R2: Writes take effect at the clock edge where `wr_en` is high. The address map is: 0 = control, 1 = pin actions, 2..5 = compare A..D, 6 = flag clear, 7 = counter load. In the control word, bit 7 is clear-on-A, bits 6:4 are the clock select, bit 3 is the D starting level and bit 2 is the C starting level. A load makes `count` equal the written value right after that edge.
- R3: With clock select 0xx, the counter advances once per 1, 2, 4 or 8 system clocks for codes 000, 001, 010 and 011. The divide comes from a free-running prescaler, so N clocks (N a multiple of the ratio) give exactly N/ratio advances.
- R4: With clock-select bit 6 set, the low two select bits are ignored. The counter advances once for each rising edge of `ext_evt`, after a two-flop synchroniser. A level held high advances the counter only once, and the prescaler has no effect.
- R5: The counter wraps from 16'hFFFF to 0.
- R6: When clear-on-A is 1, the count enable that finds `count` equal to compare A loads 0 instead of A+1. When clear-on-A is 0, counting continues past A.
- R7: Before its first compare match, pin C (D) follows the C (D) starting-level bit in the same cycle the control write lands.
- R8: A match event is the first cycle in which `count` equals a compare register. One clock after the event, the pin takes its action, using the 3-bit field in the pin-action word (C in bits 2:0, D in bits 6:4). The codes are 000 = hold, 001 = drive 0, 010 = drive 1, 011 = invert, and any 1xx = hold.
- R9: After a pin's first match, writing its starting-level bit has no effect on the pin. Only reset re-arms the starting level.
- R10: A match event on register A, B, C or D sets `match_flags` bit 0, 1, 2 or 3 one clock later. The bit stays set until software writes 1 to that bit at address 6, and writing 0 leaves a bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| ext_evt | input | 1 | External count event, asynchronous |
| count | output | 16 | Current counter value |
| match_flags | output | 4 | Sticky compare flags, A in bit 0 to D in bit 3 |
| pin_c | output | 1 | Output pin driven by compare C |
| pin_d | output | 1 | Output pin driven by compare D |

## Verification
The assertions assume that `ext_evt` stays at one level for at least three system clocks, so that the synchroniser sees every edge. The stimulus holds each external level for three or more clocks. The assertions also assume the clock select changes only through a control write. Every register write in the stimulus lasts one cycle and lands away from the clock edge. Compare values sit clear of the counts that each scenario passes through, unless a scenario is meant to hit them.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int CNT_W   = 16;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int NUM_GR  = 4;
    localparam int SEL_W   = 3;
    localparam int ACT_W   = 3;
    localparam int PRE_W   = 1 << (SEL_W - 1); // enough bits for divide-by-8 with two select bits

    localparam int GR_A = 0;
    localparam int GR_B = 1;
    localparam int GR_C = 2;
    localparam int GR_D = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_ACT  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_GR0  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_FCLR = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_LOAD = 3'd7;

    typedef struct packed {
        logic              clr_on_a;
        logic [SEL_W-1:0]  csel;
        logic              init_d;
        logic              init_c;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic next_level(input logic [ACT_W-1:0] act, input logic cur);
        case (act)
            3'b001:  return 1'b0;
            3'b010:  return 1'b1;
            3'b011:  return ~cur;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick
    import cmp_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] csel,
    input  logic             ext_in,
    output logic             tick
);

    logic [PRE_W-2:0] div_q;
    logic [2:0]       sync_q;
    logic             ext_rise;
    logic             int_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            sync_q <= '0;
        end else begin
            div_q  <= div_q + 1'b1;
            sync_q <= {sync_q[1:0], ext_in};
        end
    end

    assign ext_rise = sync_q[1] & ~sync_q[2];

    always_comb begin
        int_tick = 1'b1;
        for (int i = 0; i < PRE_W - 1; i++) begin
            if (i < int'(csel[SEL_W-2:0])) int_tick = int_tick & div_q[i];
        end
    end

    assign tick = csel[SEL_W-1] ? ext_rise : int_tick;

    // R4
    ext_single_chk: assert property (@(posedge clk) disable iff (rst)
        ext_rise |=> !ext_rise);

    // R3
    div2_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && csel == 3'b001) |=> !(tick && csel == 3'b001));

endmodule

// File: rtl/cmp_timer_outpin.sv
module cmp_timer_outpin
    import cmp_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init_lvl,
    input  logic [ACT_W-1:0] act,
    input  logic             hit,
    output logic             pin
);

    logic seen_q;
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            lvl_q  <= 1'b0;
        end else if (hit) begin
            seen_q <= 1'b1;
            lvl_q  <= next_level(act, pin);
        end
    end

    assign pin = seen_q ? lvl_q : init_lvl;

    // R9
    seen_keep_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q |=> seen_q);

    // R9
    pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !hit) |=> $stable(pin));

endmodule

// File: rtl/cmp_timer_top.sv
module cmp_timer_top
    import cmp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_evt,
    output logic [CNT_W-1:0]  count,
    output logic [NUM_GR-1:0] match_flags,
    output logic              pin_c,
    output logic              pin_d
);

    ctrl_t             ctrl_q;
    logic [ACT_W-1:0]  act_c_q;
    logic [ACT_W-1:0]  act_d_q;
    logic [CNT_W-1:0]  gr_q [NUM_GR];
    logic [CNT_W-1:0]  cnt_q;
    logic [NUM_GR-1:0] match_now;
    logic [NUM_GR-1:0] match_q;
    logic [NUM_GR-1:0] hit;
    logic [NUM_GR-1:0] flags_q;
    logic [NUM_GR-1:0] clr_mask;
    logic              tick;
    logic              load;

    assign load     = wr_en && (wr_addr == ADR_LOAD);
    assign clr_mask = (wr_en && wr_addr == ADR_FCLR) ? wr_data[NUM_GR-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            act_c_q <= '0;
            act_d_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W+1:2]);
            if (wr_addr == ADR_ACT) begin
                act_c_q <= wr_data[ACT_W-1:0];
                act_d_q <= wr_data[ACT_W+3:4];
            end
        end
    end

    for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
        always_ff @(posedge clk) begin
            if (rst) gr_q[g] <= '1;
            else if (wr_en && wr_addr == ADR_GR0 + ADDR_W'(g)) gr_q[g] <= wr_data[CNT_W-1:0];
        end
        assign match_now[g] = (cnt_q == gr_q[g]);
        assign hit[g]       = match_now[g] & ~match_q[g];
    end

    cmp_timer_tick i_tick (
        .clk    (clk),
        .rst    (rst),
        .csel   (ctrl_q.csel),
        .ext_in (ext_evt),
        .tick   (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            match_q <= '0;
            flags_q <= '0;
        end else begin
            match_q <= match_now;
            flags_q <= (flags_q & ~clr_mask) | hit;
            if (load) cnt_q <= wr_data[CNT_W-1:0];
            else if (tick) begin
                if (ctrl_q.clr_on_a && match_now[GR_A]) cnt_q <= '0;
                else                                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    cmp_timer_outpin i_pin_c (
        .clk      (clk),
        .rst      (rst),
        .init_lvl (ctrl_q.init_c),
        .act      (act_c_q),
        .hit      (hit[GR_C]),
        .pin      (pin_c)
    );

    cmp_timer_outpin i_pin_d (
        .clk      (clk),
        .rst      (rst),
        .init_lvl (ctrl_q.init_d),
        .act      (act_d_q),
        .hit      (hit[GR_D]),
        .pin      (pin_d)
    );

    assign count       = cnt_q;
    assign match_flags = flags_q;

    // R6
    clr_on_a_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && ctrl_q.clr_on_a && cnt_q == gr_q[GR_A]) |=> (count == '0));

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt_q == '1 && !(ctrl_q.clr_on_a && match_now[GR_A])) |=> (count == '0));

    // R3
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count));

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((match_flags & $past(hit)) == $past(hit)));

endmodule

// File: tb/test_cmp_timer_top.sv
module test_cmp_timer_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic        ext_evt;
    logic [15:0] count;
    logic [3:0]  match_flags;
    logic        pin_c;
    logic        pin_d;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cmp_timer_top i_cmp_timer_top (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ext_evt     (ext_evt),
        .count       (count),
        .match_flags (match_flags),
        .pin_c       (pin_c),
        .pin_d       (pin_d)
    );

    typedef struct packed {
        logic [2:0]  csel;
        logic [15:0] start;
        logic [7:0]  waits;
        logic [15:0] exp;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t TBL [NVEC] = '{
        '{3'd0, 16'd100,  8'd10, 16'd110},
        '{3'd1, 16'd200,  8'd16, 16'd208},
        '{3'd2, 16'd300,  8'd16, 16'd304},
        '{3'd3, 16'd400,  8'd32, 16'd404},
        '{3'd0, 16'hFFFE, 8'd3,  16'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            ext_evt = 1'b1;
            waitn(3);
            ext_evt = 1'b0;
            waitn(3);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ext_evt = 1'b0;
        waitn(3);
        check("R1 count",  count, 0);
        check("R1 flags",  match_flags, 0);
        check("R1 pin_c",  pin_c, 0);
        check("R1 pin_d",  pin_d, 0);
        rst = 1'b0;
        waitn(1);
        check("R1 count after reset", count, 1);

        // pins: C drive 0 (001), D invert (011); C starts high
        wr(3'd4, 16'd50);
        wr(3'd5, 16'd52);
        wr(3'd1, 16'h0031);
        wr(3'd0, 16'h0004);
        check("R7 pin_c start level", pin_c, 1);
        check("R7 pin_d start level", pin_d, 0);
        wr(3'd7, 16'd45);
        check("R2 load", count, 45);
        waitn(5);
        check("R8 pin_c before event", pin_c, 1);
        waitn(1);
        check("R8 pin_c drive 0", pin_c, 0);
        waitn(1);
        check("R8 pin_d before event", pin_d, 0);
        waitn(1);
        check("R8 pin_d invert", pin_d, 1);
        wr(3'd0, 16'h0004);
        check("R9 pin_c ignores start bit", pin_c, 0);
        check("R9 pin_d ignores start bit", pin_d, 1);
        check("R10 flags C,D", match_flags, 4'b1100);
        wr(3'd6, 16'h0004);
        check("R10 write-1 clear C", match_flags, 4'b1000);

        wr(3'd7, 16'd50);
        waitn(3);
        check("R8 pin_d invert back", pin_d, 0);
        check("R8 pin_c stays 0", pin_c, 0);
        check("R10 flag C set again", match_flags, 4'b1100);

        // C drive 1 (010), D code 110 must hold
        wr(3'd1, 16'h0062);
        wr(3'd7, 16'd48);
        waitn(6);
        check("R8 pin_c drive 1", pin_c, 1);
        check("R8 pin_d 1xx holds", pin_d, 0);

        // clock-select and wrap table
        for (int v = 0; v < NVEC; v++) begin
            wr(3'd0, {9'd0, TBL[v].csel, 4'd0});
            wr(3'd7, TBL[v].start);
            waitn(int'(TBL[v].waits));
            if (v == NVEC - 1) check("R5 wrap", count, TBL[v].exp);
            else               check("R3 ratio", count, TBL[v].exp);
        end

        // clear on A
        wr(3'd2, 16'd20);
        wr(3'd0, 16'h0080);
        wr(3'd7, 16'd18);
        waitn(2);
        check("R6 reaches A", count, 20);
        waitn(1);
        check("R6 cleared on A", count, 0);
        wr(3'd0, 16'h0000);
        wr(3'd7, 16'd18);
        waitn(3);
        check("R6 passes A when off", count, 21);
        check("R10 all flags", match_flags, 4'b1111);
        wr(3'd6, 16'h0003);
        check("R10 clear A,B only", match_flags, 4'b1100);

        // external events
        wr(3'd0, 16'h0040);
        wr(3'd7, 16'd1000);
        waitn(4);
        check("R4 no internal count", count, 1000);
        pulse(3);
        waitn(4);
        check("R4 three edges", count, 1003);
        wr(3'd0, 16'h0070);
        pulse(2);
        waitn(4);
        check("R4 low select bits ignored", count, 1005);
        ext_evt = 1'b1;
        waitn(12);
        ext_evt = 1'b0;
        waitn(4);
        check("R4 held level counts once", count, 1006);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule